// File: doc/BRIEF.md
# Serial flash continuous-read responder

This block is the device side of a four-wire serial flash interface, reduced to the two continuous array read commands. While chip select is low it collects an opcode, a 24-bit address and, for the fast command, one dummy byte from the serial input. It then streams bytes from an internal array on the serial output, most significant bit first. The read position advances byte by byte without pausing, so the host can keep clocking for as long as it needs data.

The array is organised as `PAGES` pages. A static input selects one of two page layouts. In the 528-byte layout the address holds a separate page field and byte field. In the 512-byte layout the address is a plain linear byte address. Each page occupies a 528-byte storage slot at index `page*528 + byte`. A backdoor write port fills the slots before use. In the 512-byte layout only bytes 0 to 511 of each slot are read.

The serial pins are resynchronised into `clk_i` through two flops, and edges are detected there. Each SCK high and low phase must last at least four `clk_i` cycles. `so_oe_o` is the output-enable of the serial output, and `so_o` is held low whenever the enable is off. Reading never writes the array.

Top module: `sflash_cread`

## Requirements
- R1: Opcode 0x03 is followed by 24 address bits, and the first data bit appears after the falling SCK edge that follows the last address bit.
- R2: Opcode 0x0B is followed by 24 address bits and 8 dummy bits, whose values are ignored, and the first data bit appears after the falling edge that follows the last dummy bit.
- R3: With `page528_i` = 1, address bits [21:10] give the page and bits [9:0] give the start byte. A start byte of 528 to 1023 starts at byte 0 of that page.
- R4: With `page528_i` = 0, address bits [20:0] are a linear address: bits [20:9] give the page and bits [8:0] give the byte.
- R5: A page number at or above `PAGES` is taken modulo `PAGES`, where `PAGES` is a power of two.
- R6: Serial input is sampled on rising SCK edges. Data bits change only after falling edges, most significant bit first, and hold across the rising edge.
- R7: After the last byte of a page (527 or 511, depending on mode), the next byte comes from byte 0 of the next page with no extra clocks.
- R8: After the last byte of the last page, reading continues at byte 0 of page 0 with no extra clocks.
- R9: Raising chip select ends the command and drops `so_oe_o`. The next low period starts a new command.
- R10: Any other opcode keeps `so_oe_o` low for the rest of that chip-select period.
- R11: After reset, `so_oe_o` and `so_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| page528_i | input | 1 | 1 = 528-byte page layout, 0 = 512-byte layout (static) |
| sck_i | input | 1 | Serial clock, idles low |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out, low when not enabled |
| so_oe_o | output | 1 | Output enable for so_o |
| bd_we_i | input | 1 | Backdoor write strobe |
| bd_page_i | input | PG_W | Backdoor page index |
| bd_byte_i | input | 10 | Backdoor byte index within slot (0 to 527) |
| bd_data_i | input | 8 | Backdoor write data |

## Verification
The bench goes after starts at bytes 526, 510 and 511, where a counter with the wrong terminal value shows up. Such a counter would either jump to the next page too early (at 512 in the 528 layout) or run into bytes 512 to 527 in the 512 layout. It also starts near the end of the last page, so a design that fails to wrap would read unloaded storage instead of page 0. Out-of-range page and byte fields are included, where a missing clamp or modulo reads the wrong slot. A fast read with an all-ones dummy byte would shift data by a byte if the dummy were counted as address. An unknown opcode and a mid-byte chip-select release are both included; a design that mishandles either would drive the line when it should be released, or would start the next command in the wrong phase.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned SLOT_BYTES = 528;
  localparam int unsigned LIN_BYTES  = 512;
  localparam logic [7:0]  OP_RD_SLOW = 8'h03;
  localparam logic [7:0]  OP_RD_FAST = 8'h0B;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADR,
    ST_DUM,
    ST_DAT,
    ST_IGN
  } sfr_st_e;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sfr_pos.sv
module sfr_pos
  import sfr_pkg::*;
#(
  parameter int unsigned PAGES = 4,
  localparam int unsigned PG_W = $clog2(PAGES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode528_i,
  input  logic            load_i,
  input  logic [23:0]     addr_i,
  input  logic            adv_i,
  output logic [PG_W-1:0] page_o,
  output logic [9:0]      byte_o
);
  localparam logic [9:0] TERM_528 = 10'(SLOT_BYTES - 1);
  localparam logic [9:0] TERM_512 = 10'(LIN_BYTES - 1);

  logic [PG_W-1:0] page_q, ld_page;
  logic [9:0]      byte_q, ld_byte, term;

  always_comb begin
    if (mode528_i) begin
      ld_page = addr_i[10 +: PG_W];
      ld_byte = (addr_i[9:0] > TERM_528) ? 10'd0 : addr_i[9:0];
    end else begin
      ld_page = addr_i[9 +: PG_W];
      ld_byte = {1'b0, addr_i[8:0]};
    end
    term = mode528_i ? TERM_528 : TERM_512;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      byte_q <= '0;
    end else if (load_i) begin
      page_q <= ld_page;
      byte_q <= ld_byte;
    end else if (adv_i) begin
      if (byte_q >= term) begin
        byte_q <= '0;
        page_q <= page_q + 1'b1;  // power-of-two page count wraps naturally
      end else begin
        byte_q <= byte_q + 10'd1;
      end
    end
  end

  assign page_o = page_q;
  assign byte_o = byte_q;

  p_page_roll_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && byte_q == term) |=> (byte_q == 10'd0 && page_q == $past(page_q) + 1'b1));

  p_in_page_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && byte_q < term) |=> (byte_q == $past(byte_q) + 10'd1 && $stable(page_q)));

  p_byte_in_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_q < 10'(SLOT_BYTES));
endmodule

// File: rtl/sfr_array.sv
module sfr_array
  import sfr_pkg::*;
#(
  parameter int unsigned PAGES = 4,
  localparam int unsigned PG_W  = $clog2(PAGES),
  localparam int unsigned DEPTH = PAGES * SLOT_BYTES,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [PG_W-1:0] wpage_i,
  input  logic [9:0]      wbyte_i,
  input  logic [7:0]      wdata_i,
  input  logic [PG_W-1:0] rpage_i,
  input  logic [9:0]      rbyte_i,
  output logic [7:0]      rdata_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [IDX_W-1:0] widx, ridx;

  assign widx = IDX_W'(32'(wpage_i) * SLOT_BYTES + 32'(wbyte_i));
  assign ridx = IDX_W'(32'(rpage_i) * SLOT_BYTES + 32'(rbyte_i));

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx] <= wdata_i;
    rdata_o <= mem_q[ridx];
  end
endmodule

// File: rtl/sflash_cread.sv
module sflash_cread
  import sfr_pkg::*;
#(
  parameter int unsigned PAGES = 4,
  localparam int unsigned PG_W = $clog2(PAGES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            page528_i,
  input  logic            sck_i,
  input  logic            cs_ni,
  input  logic            si_i,
  output logic            so_o,
  output logic            so_oe_o,
  input  logic            bd_we_i,
  input  logic [PG_W-1:0] bd_page_i,
  input  logic [9:0]      bd_byte_i,
  input  logic [7:0]      bd_data_i
);
  logic [2:0]  pins_s;
  logic        sck_s, cs_s, si_s, sck_q, rise, fall;
  sfr_st_e     st_q;
  logic [23:0] sh_q, sh_nx;
  logic [4:0]  cnt_q;
  logic        fast_q, oe_q;
  logic [7:0]  txb_q, mem_rd;
  logic [2:0]  bit_q;
  logic        load, adv;
  logic [PG_W-1:0] cur_page;
  logic [9:0]      cur_byte;

  sfr_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, si_i}),
    .q_o   (pins_s)
  );
  assign {sck_s, cs_s, si_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s;
  end

  assign rise  = sck_s & ~sck_q;
  assign fall  = ~sck_s & sck_q;
  assign sh_nx = {sh_q[22:0], si_s};
  assign load  = !cs_s && rise && st_q == ST_ADR && cnt_q == 5'd23;
  assign adv   = !cs_s && fall && st_q == ST_DAT && bit_q == 3'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OPC;
      sh_q   <= '0;
      cnt_q  <= '0;
      fast_q <= 1'b0;
      oe_q   <= 1'b0;
      txb_q  <= '0;
      bit_q  <= '0;
    end else if (cs_s) begin
      st_q  <= ST_OPC;
      cnt_q <= '0;
      oe_q  <= 1'b0;
      bit_q <= '0;
    end else begin
      if (rise) begin
        unique case (st_q)
          ST_OPC: begin
            sh_q <= sh_nx;
            if (cnt_q == 5'd7) begin
              cnt_q <= '0;
              if (sh_nx[7:0] == OP_RD_FAST) begin
                st_q <= ST_ADR; fast_q <= 1'b1;
              end else if (sh_nx[7:0] == OP_RD_SLOW) begin
                st_q <= ST_ADR; fast_q <= 1'b0;
              end else begin
                st_q <= ST_IGN;
              end
            end else cnt_q <= cnt_q + 5'd1;
          end
          ST_ADR: begin
            sh_q <= sh_nx;
            if (cnt_q == 5'd23) begin
              cnt_q <= '0;
              st_q  <= fast_q ? ST_DUM : ST_DAT;
            end else cnt_q <= cnt_q + 5'd1;
          end
          ST_DUM: begin
            if (cnt_q == 5'd7) begin
              cnt_q <= '0;
              st_q  <= ST_DAT;
            end else cnt_q <= cnt_q + 5'd1;
          end
          default: ;  // data and ignore phases take no input
        endcase
      end
      if (fall && st_q == ST_DAT) begin
        oe_q  <= 1'b1;
        bit_q <= bit_q + 3'd1;
        txb_q <= (bit_q == 3'd0) ? mem_rd : {txb_q[6:0], 1'b0};
      end
    end
  end

  // position holds the next byte to fetch; mem_rd settles two clocks after a change
  sfr_pos #(.PAGES(PAGES)) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode528_i(page528_i),
    .load_i   (load),
    .addr_i   (sh_nx),
    .adv_i    (adv),
    .page_o   (cur_page),
    .byte_o   (cur_byte)
  );

  sfr_array #(.PAGES(PAGES)) u_array (
    .clk_i  (clk_i),
    .we_i   (bd_we_i),
    .wpage_i(bd_page_i),
    .wbyte_i(bd_byte_i),
    .wdata_i(bd_data_i),
    .rpage_i(cur_page),
    .rbyte_i(cur_byte),
    .rdata_o(mem_rd)
  );

  assign so_oe_o = oe_q;
  assign so_o    = oe_q & txb_q[7];

  p_cs_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !so_oe_o);

  p_ign_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IGN) |-> !so_oe_o);

  p_drive_only_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (st_q == ST_DAT));

  p_hold_off_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall && !cs_s && so_oe_o) |=> $stable(so_o));

  p_load_then_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !fast_q) |=> (st_q == ST_DAT || cs_s));
endmodule

// File: tb/sim_sflash_cread.sv
module sim_sflash_cread;
  localparam int CLK_NS = 10;
  localparam int HALF   = 6;
  localparam int PAGES  = 4;
  localparam int PG_W   = $clog2(PAGES);
  localparam int NVEC   = 9;
  localparam int NRD    = 4;

  // {layout528, opcode, address}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 8'h03, 24'h000405},  // p1 b5
    {1'b1, 8'h0B, 24'h000A0E},  // p2 b526 -> page roll
    {1'b1, 8'h03, 24'h000E0E},  // p3 b526 -> array wrap
    {1'b1, 8'h03, 24'h000658},  // p1 b600 -> clamp to b0
    {1'b1, 8'h03, 24'h001403},  // p5 -> p1
    {1'b0, 8'h03, 24'h0005FE},  // linear 1534 -> roll at 511
    {1'b0, 8'h0B, 24'h0007FE},  // linear 2046 -> wrap
    {1'b0, 8'h03, 24'h000C07},  // page 6 -> 2
    {1'b1, 8'h0B, 24'h0001FF}   // b511 must not roll in 528 layout
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic page528 = 1'b1, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe;
  logic bd_we = 1'b0;
  logic [PG_W-1:0] bd_page = '0;
  logic [9:0] bd_byte = '0;
  logic [7:0] bd_data = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  sflash_cread #(.PAGES(PAGES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .page528_i(page528), .sck_i(sck), .cs_ni(cs_n),
    .si_i(si), .so_o(so), .so_oe_o(so_oe), .bd_we_i(bd_we), .bd_page_i(bd_page),
    .bd_byte_i(bd_byte), .bd_data_i(bd_data)
  );

  function automatic logic [7:0] pat(input int pg, input int by);
    logic [9:0] b = by[9:0];
    return 8'(pg * 71) ^ b[7:0] ^ {b[9:8], 6'h15};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one SCK period: input presented in low phase; output sampled late low and late high
  task automatic xfer(input logic b, output logic o_lo, output logic o_hi, output logic oe);
    si = b;
    repeat (HALF) @(negedge clk);
    o_lo = so; oe = so_oe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    o_hi = so;
    sck = 1'b0;
  endtask

  task automatic send(input logic [7:0] v);
    logic a, c, d;
    for (int i = 7; i >= 0; i--) xfer(v[i], a, c, d);
  endtask

  task automatic recv(output logic [7:0] v, output bit all_oe, output bit any_oe, output bit steady);
    logic lo, hi, oe;
    all_oe = 1'b1; any_oe = 1'b0; steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      xfer(1'b0, lo, hi, oe);
      v[i] = lo;
      all_oe &= oe; any_oe |= oe;
      if (lo !== hi) steady = 1'b0;
    end
  endtask

  task automatic cs_off();
    sck = 1'b0; cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic string vtag(input int i);
    case (i)
      0: return "R1 R3";
      1: return "R2 R7";
      2: return "R8 R3";
      3: return "R3";
      4: return "R5";
      5: return "R4 R7";
      6: return "R2 R8";
      7: return "R4 R5";
      default: return "R2 R3";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit all_oe, any_oe, steady;
    int pg, by;
    repeat (3) @(negedge clk);
    chk(so_oe === 1'b0 && so === 1'b0, "R11 reset outputs", {so_oe, so}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(so_oe === 1'b0, "R11 idle after reset", so_oe, 0);

    for (int p = 0; p < PAGES; p++)
      for (int b = 0; b < 528; b++) begin
        bd_we = 1'b1; bd_page = PG_W'(p); bd_byte = 10'(b); bd_data = pat(p, b);
        @(negedge clk);
      end
    bd_we = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic m528 = VEC[i][32];
      logic [7:0] op = VEC[i][31:24];
      logic [23:0] a = VEC[i][23:0];
      page528 = m528;
      repeat (4) @(negedge clk);
      if (m528) begin
        pg = int'(a[21:10]) % PAGES; by = int'(a[9:0]);
        if (by >= 528) by = 0;
      end else begin
        pg = int'(a[20:9]) % PAGES; by = int'(a[8:0]);
      end
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      send(op); send(a[23:16]); send(a[15:8]); send(a[7:0]);
      if (op == 8'h0B) send(8'hFF);
      for (int k = 0; k < NRD; k++) begin
        recv(v, all_oe, any_oe, steady);
        chk(v === pat(pg, by), $sformatf("%s vec%0d byte%0d", vtag(i), i, k), v, pat(pg, by));
        chk(all_oe && steady, $sformatf("R6 vec%0d byte%0d drive", i, k), {all_oe, steady}, 3);
        by++;
        if (by == (m528 ? 528 : 512)) begin by = 0; pg = (pg + 1) % PAGES; end
      end
      cs_off();
      chk(so_oe === 1'b0, $sformatf("R9 vec%0d release", i), so_oe, 0);
    end

    // unknown opcode: line stays released for the whole select period
    page528 = 1'b1;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    send(8'h9F); send(8'h00); send(8'h04); send(8'h00);
    for (int k = 0; k < 3; k++) begin
      recv(v, all_oe, any_oe, steady);
      chk(!any_oe && v === 8'h00, "R10 unknown opcode", {any_oe, v}, 0);
    end
    cs_off();

    // abort mid-byte, then a fresh read must start in the opcode phase
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    send(8'h03); send(8'h00); send(8'h04); send(8'h00);
    recv(v, all_oe, any_oe, steady);
    chk(v === pat(1, 0), "R9 before abort", v, pat(1, 0));
    begin
      logic a, c, d;
      for (int k = 0; k < 3; k++) xfer(1'b0, a, c, d);
    end
    cs_off();
    chk(so_oe === 1'b0 && so === 1'b0, "R9 abort release", {so_oe, so}, 0);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    send(8'h03); send(8'h00); send(8'h0C); send(8'h0F);
    recv(v, all_oe, any_oe, steady);
    chk(v === pat(3, 15), "R9 restart after abort", v, pat(3, 15));
    cs_off();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule